// File: doc/BRIEF.md
# Indexed Power Setting Table

This block keeps eight byte-wide amplifier power settings and lets a serial configuration port fill and inspect them without ever sending an address. A hidden index counter picks the entry that each data byte goes to or comes from. The counter steps forward after every byte, wraps from the last entry back to the first, and returns to entry zero whenever chip-select is released. A host therefore always starts a transfer at entry zero, and a burst longer than the table continues from the top again.

The serial shifter sits outside the block and delivers whole bytes as single-cycle strobes. Separately, a 3-bit power-select input picks one entry at any time, and the picked value is driven to the amplifier control output through logic alone. When the chip enters its sleep state, every entry is wiped to zero.

Top module: `power_table`

## Requirements
- R1: While `rst_n` is low, every entry reads 0x00, `rd_data` is 0x00 and the index is 0, so the first byte after reset goes to entry 0.
- R2: A clock edge with `cs_n` low and `wr_stb` high stores `wr_data` in the entry at the current index, and the index then moves to the next entry.
- R3: A clock edge with `cs_n` low, `rd_stb` high and `wr_stb` low loads `rd_data` with the entry at the index before the step, and the index then steps. At every other edge `rd_data` keeps its value.
- R4: The index steps from entry 7 to entry 0, so the ninth byte of a burst reaches entry 0, for writes and for reads alike.
- R5: While `cs_n` is high the index is forced to 0 and both strobes are ignored: no entry changes and `rd_data` holds.
- R6: When `wr_stb` and `rd_stb` are both high with `cs_n` low, the edge performs only the write. `rd_data` holds and the index steps exactly once.
- R7: An edge at which `sleep` is high after being low (entry into sleep) sets all eight entries to 0x00. This clear takes priority over a write at the same edge. The index is not affected by sleep.
- R8: `pa_setting` always equals the entry chosen by `pwr_sel` (0 to 7). After a write edge to that entry it shows the new value, with no extra register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip-select from the serial port, active low |
| wr_stb | input | 1 | One-cycle strobe: a byte is to be written |
| wr_data | input | 8 | Byte to be written |
| rd_stb | input | 1 | One-cycle strobe: a byte is to be read |
| pwr_sel | input | 3 | Power level that selects the entry for the amplifier |
| sleep | input | 1 | High while the chip is in sleep state |
| rd_data | output | 8 | Last byte read through the index |
| pa_setting | output | 8 | Entry selected by `pwr_sel` |

## Verification
The properties assume that each strobe stands for exactly one byte and stays high for a single clock cycle. They also assume that `pwr_sel` and `sleep` are clean synchronous levels, so that a rising `sleep` seen at one edge is a real sleep entry. The bench drives every input at the falling clock edge and never widens a strobe. Strobes that arrive while `cs_n` is high, and strobes that arrive together, are applied on purpose, because the block must give both cases a defined meaning. Sleep is raised once while a write is pending, and is held across a read, so that the clear-over-write priority and the rule that only the sleep entry clears are both exercised.

// File: rtl/pwr_tbl_pkg.sv
package pwr_tbl_pkg;
  // byte-level access decoded from the strobes
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;

  // write wins over read when both strobes arrive together (R6)
  function automatic acc_e decode_acc(input logic cs_n, input logic wr, input logic rd);
    if (cs_n)    return ACC_IDLE;
    else if (wr) return ACC_WRITE;
    else if (rd) return ACC_READ;
    else         return ACC_IDLE;
  endfunction
endpackage

// File: rtl/ptab_index.sv
module ptab_index #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] idx_d, idx_q;
  logic             idx_en;

  always_comb begin
    idx_en = cs_n | step;
    idx_d  = idx_q;
    if (cs_n)              idx_d = '0;          // R5
    else if (idx_q == LAST) idx_d = '0;         // R4
    else                    idx_d = idx_q + 1'b1; // R2
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/ptab_store.sv
module ptab_store #(
  parameter int N_ENTRIES = 8,
  parameter int ENTRY_W   = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wipe,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [IDX_W-1:0]   sel_idx,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic [ENTRY_W-1:0] sel_entry
);
  logic [N_ENTRIES-1:0][ENTRY_W-1:0] ent_q;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic               en;
    logic [ENTRY_W-1:0] d;

    always_comb begin
      en = wipe | (wr_en & (wr_idx == IDX_W'(g)));
      d  = wipe ? '0 : wr_data;               // R7: wipe beats write
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[g] <= '0;
      else if (en) ent_q[g] <= d;
    end
  end

  assign rd_entry  = ent_q[rd_idx];
  assign sel_entry = ent_q[sel_idx];           // R8: combinational lookup
endmodule

// File: rtl/power_table.sv
module power_table #(
  parameter int N_ENTRIES = 8,
  parameter int ENTRY_W   = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               wr_stb,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               rd_stb,
  input  logic [IDX_W-1:0]   pwr_sel,
  input  logic               sleep,
  output logic [ENTRY_W-1:0] rd_data,
  output logic [ENTRY_W-1:0] pa_setting
);
  import pwr_tbl_pkg::*;

  acc_e               acc;
  logic [IDX_W-1:0]   idx_q;
  logic [ENTRY_W-1:0] rd_entry;
  logic               sleep_q;
  logic               sleep_entry;
  logic               rd_en;
  logic [ENTRY_W-1:0] rd_data_q;

  always_comb begin
    acc         = decode_acc(cs_n, wr_stb, rd_stb);
    sleep_entry = sleep & ~sleep_q;
    rd_en       = (acc == ACC_READ);
  end

  ptab_index #(.N_ENTRIES(N_ENTRIES)) u_index (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .step  (acc != ACC_IDLE),
    .idx   (idx_q)
  );

  ptab_store #(.N_ENTRIES(N_ENTRIES), .ENTRY_W(ENTRY_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wipe      (sleep_entry),
    .wr_en     (acc == ACC_WRITE),
    .wr_idx    (idx_q),
    .wr_data   (wr_data),
    .rd_idx    (idx_q),
    .sel_idx   (pwr_sel),
    .rd_entry  (rd_entry),
    .sel_entry (pa_setting)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_entry;   // R3
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/ptab_checker.sv
module ptab_checker #(
  parameter int N_ENTRIES = 8,
  parameter int ENTRY_W   = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               wr_stb,
  input logic               rd_stb,
  input logic [ENTRY_W-1:0] wr_data,
  input logic [IDX_W-1:0]   pwr_sel,
  input logic               sleep,
  input logic [IDX_W-1:0]   idx,
  input logic [ENTRY_W-1:0] rd_data,
  input logic [ENTRY_W-1:0] pa_setting
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic slp_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slp_d <= 1'b0;
    else        slp_d <= sleep;
  end

  p_idx_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (idx == '0));

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (wr_stb || rd_stb)) |=>
      (idx == (($past(idx) == LAST) ? '0 : $past(idx) + 1'b1)));

  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_stb && !rd_stb) |=> $stable(idx));

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_n && rd_stb && !wr_stb) |=> $stable(rd_data));

  p_write_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && wr_stb && !(sleep && !slp_d)) |=>
      ((pwr_sel != $past(idx)) || (pa_setting == $past(wr_data))));

  p_sleep_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !slp_d) |=> (pa_setting == '0));
endmodule

bind power_table ptab_checker #(.N_ENTRIES(N_ENTRIES), .ENTRY_W(ENTRY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .wr_stb     (wr_stb),
  .rd_stb     (rd_stb),
  .wr_data    (wr_data),
  .pwr_sel    (pwr_sel),
  .sleep      (sleep),
  .idx        (idx_q),
  .rd_data    (rd_data),
  .pa_setting (pa_setting)
);

// File: tb/power_table_test.sv
module power_table_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, wr_stb, rd_stb, sleep;
  logic [7:0] wr_data;
  logic [2:0] pwr_sel;
  logic [7:0] rd_data, pa_setting;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  power_table uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .pwr_sel(pwr_sel), .sleep(sleep),
    .rd_data(rd_data), .pa_setting(pa_setting)
  );

  typedef struct packed {
    logic       cs_n;
    logic       wr;
    logic       rd;
    logic [7:0] wd;
    logic [2:0] sel;
    logic       slp;
    logic [7:0] exp_rd;
    logic [7:0] exp_pa;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,8'h00,3'd0,1'b0,8'h00,8'h00,4'd5}, // idle, deselected
    '{1'b0,1'b1,1'b0,8'h11,3'd0,1'b0,8'h00,8'h11,4'd2}, // R2 entry0
    '{1'b0,1'b1,1'b0,8'h22,3'd1,1'b0,8'h00,8'h22,4'd2},
    '{1'b0,1'b1,1'b0,8'h33,3'd2,1'b0,8'h00,8'h33,4'd2},
    '{1'b0,1'b1,1'b0,8'h44,3'd3,1'b0,8'h00,8'h44,4'd8}, // R8
    '{1'b0,1'b1,1'b0,8'h55,3'd4,1'b0,8'h00,8'h55,4'd8},
    '{1'b0,1'b1,1'b0,8'h66,3'd5,1'b0,8'h00,8'h66,4'd2},
    '{1'b0,1'b1,1'b0,8'h77,3'd6,1'b0,8'h00,8'h77,4'd2},
    '{1'b0,1'b1,1'b0,8'h88,3'd7,1'b0,8'h00,8'h88,4'd2}, // entry7
    '{1'b0,1'b1,1'b0,8'h99,3'd0,1'b0,8'h00,8'h99,4'd4}, // R4 ninth byte to entry0
    '{1'b1,1'b0,1'b0,8'h00,3'd1,1'b0,8'h00,8'h22,4'd5}, // R5 index back to 0
    '{1'b0,1'b0,1'b1,8'h00,3'd0,1'b0,8'h99,8'h99,4'd3}, // R3 read entry0
    '{1'b0,1'b0,1'b1,8'h00,3'd2,1'b0,8'h22,8'h33,4'd3}, // read entry1
    '{1'b0,1'b0,1'b0,8'h00,3'd3,1'b0,8'h22,8'h44,4'd3}, // rd_data holds
    '{1'b1,1'b1,1'b1,8'hAA,3'd0,1'b0,8'h22,8'h99,4'd5}, // R5 strobes ignored
    '{1'b0,1'b1,1'b1,8'hBB,3'd0,1'b0,8'h22,8'hBB,4'd6}, // R6 write wins
    '{1'b0,1'b0,1'b1,8'h00,3'd1,1'b0,8'h22,8'h22,4'd6}, // index stepped once
    '{1'b0,1'b1,1'b0,8'hCC,3'd2,1'b1,8'h22,8'h00,4'd7}, // R7 wipe beats write
    '{1'b0,1'b0,1'b1,8'h00,3'd0,1'b1,8'h00,8'h00,4'd7}, // entry3 wiped, idx kept
    '{1'b1,1'b0,1'b0,8'h00,3'd7,1'b0,8'h00,8'h00,4'd7}
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic w, input logic r,
                       input logic [7:0] d, input logic [2:0] s, input logic sl);
    cs_n = c; wr_stb = w; rd_stb = r; wr_data = d; pwr_sel = s; sleep = sl;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1", "rd_data in reset", rd_data, 8'h00);
    check("R1", "pa_setting in reset", pa_setting, 8'h00);
    rst_n = 1'b1;

    // vector walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].cs_n, VEC[i].wr, VEC[i].rd, VEC[i].wd, VEC[i].sel, VEC[i].slp);
      @(negedge clk);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d rd_data", i), rd_data, VEC[i].exp_rd);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d pa_setting", i), pa_setting, VEC[i].exp_pa);
    end

    // R4 read burst wraps: fill, deselect, read nine bytes
    for (int k = 0; k < 8; k++) begin
      drive(1'b0, 1'b1, 1'b0, 8'hA0 + 8'(k), 3'(k), 1'b0);
      @(negedge clk);
      check("R8", "fill pa_setting", pa_setting, 8'hA0 + 8'(k));
    end
    drive(1'b1, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0);
    @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      drive(1'b0, 1'b0, 1'b1, 8'h00, 3'd0, 1'b0);
      @(negedge clk);
      check("R4", "read burst rd_data", rd_data, 8'hA0 + 8'(k % 8));
    end

    // R1 reset mid-transfer: index and table cleared
    drive(1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      pwr_sel = 3'(s);
      #0.5;
      check("R1", "entry after reset", pa_setting, 8'h00);
    end
    check("R1", "rd_data after reset", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 8'h5A, 3'd0, 1'b0);
    @(negedge clk);
    check("R1", "first write lands in entry0", pa_setting, 8'h5A);
    drive(1'b1, 1'b0, 1'b0, 8'h00, 3'd1, 1'b0);
    @(negedge clk);
    check("R1", "entry1 untouched", pa_setting, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule